// File: doc/BRIEF.md
# Dual-Width Register and Stack Pointer File

This block holds a processor's accumulator, two index registers and system stack pointer. All four are 16 bits wide, and code written for an 8-bit machine still runs on them unchanged. Each register loads from a shared data bus through its own enable. A single width flag sets what a load does. An 8-bit load forces a fixed upper byte: 0x00 for the accumulator and both index registers, and page 0x01 for the system stack pointer. A 16-bit load writes the whole register, so the register can point anywhere in the address space.

The block also applies push and pull operations to a stack pointer and outputs the 16-bit stack address for that cycle. The pointer is either the system stack pointer or the Y index register, which can act as an auxiliary stack pointer. A push addresses the current pointer and then decrements it. A pull increments the pointer first and addresses the new value. In 8-bit stack mode only the low byte steps, so the pointer wraps inside its current page. In 16-bit stack mode the carry or borrow reaches the upper byte. Instruction decode and the ALU drive every control input.

Top module: `dual_width_regfile`

## Requirements
- R1: After reset the accumulator, X and Y read 0x0000 and the system stack pointer reads 0x0100.
- R2: An 8-bit load (ld_wide=0) into the accumulator, X or Y writes ld_data[7:0] into the low byte and 0x00 into the upper byte.
- R3: An 8-bit load into the system stack pointer writes ld_data[7:0] into the low byte and 0x01 into the upper byte.
- R4: A 16-bit load (ld_wide=1) writes all 16 bits of ld_data into the selected register.
- R5: A push puts the current pointer on stk_addr in the same cycle, and the pointer is one lower after the clock edge.
- R6: A pull puts the pointer plus one on stk_addr in the same cycle, and the pointer takes that value after the clock edge.
- R7: With stk_wide=0 a push or pull changes only the low byte: 0x0100 pushes to 0x01FF and 0x01FF pulls to 0x0100.
- R8: With stk_wide=1 the step carries into the upper byte: 0xF200 pushes to 0xF1FF, and 0xF1FF pulls to 0xF200.
- R9: A stack page set by a 16-bit load stays in place through 8-bit pushes and pulls, until an 8-bit load into the stack pointer restores page 0x01.
- R10: With stk_sel=1 pushes and pulls use and update Y, and the system stack pointer is left unchanged. With stk_sel=0 they use the system stack pointer.
- R11: A load into the register that is currently the stack pointer takes priority over a push or pull in the same cycle. If push and pull are both high, the push is performed.
- R12: A register with no load and no stack operation holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_a | input | 1 | Load enable for the accumulator |
| ld_x | input | 1 | Load enable for X |
| ld_y | input | 1 | Load enable for Y |
| ld_s | input | 1 | Load enable for the system stack pointer |
| ld_wide | input | 1 | Load width flag: 1 = 16-bit, 0 = 8-bit with the upper byte forced |
| ld_data | input | 16 | Load data |
| push | input | 1 | Push: address the pointer, then decrement it |
| pull | input | 1 | Pull: increment the pointer, then address it |
| stk_sel | input | 1 | Stack pointer select: 0 = system stack pointer, 1 = Y |
| stk_wide | input | 1 | Stack step width: 1 = 16-bit, 0 = low byte only |
| a_q | output | 16 | Accumulator |
| x_q | output | 16 | X index register |
| y_q | output | 16 | Y index register / auxiliary stack pointer |
| s_q | output | 16 | System stack pointer |
| stk_addr | output | 16 | Stack address for the current push or pull |

## Verification
The assertions check, on every cycle, the upper byte that an 8-bit load forces, the exact value that a 16-bit load writes, the pointer movement after a push or pull, the address that a pull presents, and that the system stack pointer is left unchanged while Y serves as the stack pointer. Other properties depend on a sequence of operations, and only the bench scenarios show them. These are the persistence of a relocated stack page through several 8-bit stack operations, the wrap inside a page, the carry across a page boundary, load-over-stack priority, and the values after reset.

// File: rtl/dual_width_regfile.sv
module dual_width_regfile #(
  parameter int W = 16,
  parameter logic [W/2-1:0] SYS_PAGE = 'h01
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_a,
  input  logic         ld_x,
  input  logic         ld_y,
  input  logic         ld_s,
  input  logic         ld_wide,
  input  logic [W-1:0] ld_data,
  input  logic         push,
  input  logic         pull,
  input  logic         stk_sel,
  input  logic         stk_wide,
  output logic [W-1:0] a_q,
  output logic [W-1:0] x_q,
  output logic [W-1:0] y_q,
  output logic [W-1:0] s_q,
  output logic [W-1:0] stk_addr
);
  localparam int H = W / 2;

  function automatic logic [W-1:0] step_ptr(input logic [W-1:0] p, input logic up,
                                            input logic wide);
    logic [H-1:0] lo;
    if (wide) return up ? p + W'(1) : p - W'(1);
    lo = up ? p[H-1:0] + H'(1) : p[H-1:0] - H'(1);
    return {p[W-1:H], lo};
  endfunction

  logic           do_pull, stk_act;
  logic [W-1:0]   cur_ptr, nxt_ptr, data_ld, stk_ld;

  assign do_pull  = pull & ~push;
  assign stk_act  = push | pull;
  assign cur_ptr  = stk_sel ? y_q : s_q;
  assign nxt_ptr  = step_ptr(cur_ptr, do_pull, stk_wide);
  assign stk_addr = do_pull ? nxt_ptr : cur_ptr;

  assign data_ld = ld_wide ? ld_data : {{H{1'b0}}, ld_data[H-1:0]};
  assign stk_ld  = ld_wide ? ld_data : {SYS_PAGE, ld_data[H-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      x_q <= '0;
      y_q <= '0;
      s_q <= {SYS_PAGE, {H{1'b0}}};
    end else begin
      if (ld_a) a_q <= data_ld;
      if (ld_x) x_q <= data_ld;
      if (ld_y)                        y_q <= data_ld;
      else if (stk_act && stk_sel)     y_q <= nxt_ptr;
      if (ld_s)                        s_q <= stk_ld;
      else if (stk_act && !stk_sel)    s_q <= nxt_ptr;
    end
  end
endmodule

module dual_width_regfile_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ld_a,
  input logic         ld_x,
  input logic         ld_s,
  input logic         ld_wide,
  input logic [W-1:0] ld_data,
  input logic         push,
  input logic         pull,
  input logic         stk_sel,
  input logic         stk_wide,
  input logic [W-1:0] a_q,
  input logic [W-1:0] x_q,
  input logic [W-1:0] s_q,
  input logic [W-1:0] stk_addr
);
  localparam int H = W / 2;

  AST_A_NARROW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_a && !ld_wide) |=> (a_q[W-1:H] == '0)); // R2
  AST_X_NARROW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_x && !ld_wide) |=> (x_q[W-1:H] == '0)); // R2
  AST_S_NARROW_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_s && !ld_wide) |=> (s_q[W-1:H] == H'(1))); // R3
  AST_A_WIDE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_a && ld_wide) |=> (a_q == $past(ld_data))); // R4
  AST_PUSH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !stk_sel) |-> (stk_addr == s_q)); // R5
  AST_PUSH_NARROW_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !stk_sel && !ld_s && !stk_wide) |=>
      (s_q[W-1:H] == $past(s_q[W-1:H]) && s_q[H-1:0] == $past(s_q[H-1:0]) - H'(1))); // R7
  AST_PULL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (pull && !push && !stk_sel && !ld_s) |=> (s_q == $past(stk_addr))); // R6
  AST_AUX_KEEPS_S: assert property (@(posedge clk) disable iff (!rst_n)
    ((push || pull) && stk_sel && !ld_s) |=> $stable(s_q)); // R10
  AST_A_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_a |=> $stable(a_q)); // R12
endmodule

bind dual_width_regfile dual_width_regfile_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ld_a(ld_a), .ld_x(ld_x), .ld_s(ld_s),
  .ld_wide(ld_wide), .ld_data(ld_data), .push(push), .pull(pull),
  .stk_sel(stk_sel), .stk_wide(stk_wide), .a_q(a_q), .x_q(x_q),
  .s_q(s_q), .stk_addr(stk_addr)
);

// File: tb/dual_width_regfile_tb_top.sv
module dual_width_regfile_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_a = 0, ld_x = 0, ld_y = 0, ld_s = 0, ld_wide = 0;
  logic [15:0] ld_data = '0;
  logic push = 0, pull = 0, stk_sel = 0, stk_wide = 0;
  logic [15:0] a_q, x_q, y_q, s_q, stk_addr;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dual_width_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .ld_a(ld_a), .ld_x(ld_x), .ld_y(ld_y), .ld_s(ld_s),
    .ld_wide(ld_wide), .ld_data(ld_data), .push(push), .pull(pull),
    .stk_sel(stk_sel), .stk_wide(stk_wide), .a_q(a_q), .x_q(x_q), .y_q(y_q),
    .s_q(s_q), .stk_addr(stk_addr)
  );

  typedef struct packed {
    logic [3:0]  ld;
    logic        wide;
    logic [15:0] data;
    logic        psh, pll, sel, swide, chka;
    logic [15:0] ea, ex, ey, es, eaddr;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{4'b1000, 1'b0, 16'hBEEF, 0,0,0,0,0, 16'h00EF,16'h0000,16'h0000,16'h0100,16'h0000, 4'd2},  // R2
    '{4'b0100, 1'b1, 16'h1234, 0,0,0,0,0, 16'h00EF,16'h1234,16'h0000,16'h0100,16'h0000, 4'd4},  // R4
    '{4'b0100, 1'b0, 16'hAB55, 0,0,0,0,0, 16'h00EF,16'h0055,16'h0000,16'h0100,16'h0000, 4'd2},  // R2
    '{4'b0010, 1'b1, 16'h8001, 0,0,0,0,0, 16'h00EF,16'h0055,16'h8001,16'h0100,16'h0000, 4'd4},  // R4
    '{4'b0000, 1'b0, 16'h0000, 1,0,0,0,1, 16'h00EF,16'h0055,16'h8001,16'h01FF,16'h0100, 4'd7},  // R5 R7
    '{4'b0000, 1'b0, 16'h0000, 0,1,0,0,1, 16'h00EF,16'h0055,16'h8001,16'h0100,16'h0100, 4'd6},  // R6 R7
    '{4'b0001, 1'b1, 16'hF200, 0,0,0,0,0, 16'h00EF,16'h0055,16'h8001,16'hF200,16'h0000, 4'd4},  // R4
    '{4'b0000, 1'b0, 16'h0000, 1,0,0,0,1, 16'h00EF,16'h0055,16'h8001,16'hF2FF,16'hF200, 4'd9},  // R9
    '{4'b0000, 1'b0, 16'h0000, 0,1,0,0,1, 16'h00EF,16'h0055,16'h8001,16'hF200,16'hF200, 4'd9},  // R9
    '{4'b0000, 1'b0, 16'h0000, 1,0,0,1,1, 16'h00EF,16'h0055,16'h8001,16'hF1FF,16'hF200, 4'd8},  // R8
    '{4'b0000, 1'b0, 16'h0000, 0,1,0,1,1, 16'h00EF,16'h0055,16'h8001,16'hF200,16'hF200, 4'd8},  // R8
    '{4'b0001, 1'b0, 16'h7734, 0,0,0,0,0, 16'h00EF,16'h0055,16'h8001,16'h0134,16'h0000, 4'd3},  // R3 R9
    '{4'b0000, 1'b0, 16'h0000, 1,0,1,0,1, 16'h00EF,16'h0055,16'h8000,16'h0134,16'h8001, 4'd10}, // R10
    '{4'b0000, 1'b0, 16'h0000, 1,0,1,0,1, 16'h00EF,16'h0055,16'h80FF,16'h0134,16'h8000, 4'd10}, // R10 R7
    '{4'b0000, 1'b0, 16'h0000, 0,1,1,1,1, 16'h00EF,16'h0055,16'h8100,16'h0134,16'h8100, 4'd10}, // R10 R8
    '{4'b0010, 1'b0, 16'h3377, 0,0,0,0,0, 16'h00EF,16'h0055,16'h0077,16'h0134,16'h0000, 4'd2},  // R2
    '{4'b0001, 1'b1, 16'h2000, 1,0,0,0,0, 16'h00EF,16'h0055,16'h0077,16'h2000,16'h0000, 4'd11}, // R11
    '{4'b0000, 1'b0, 16'h0000, 1,1,0,0,1, 16'h00EF,16'h0055,16'h0077,16'h20FF,16'h2000, 4'd11}, // R11
    '{4'b0000, 1'b1, 16'hFFFF, 0,0,0,0,0, 16'h00EF,16'h0055,16'h0077,16'h20FF,16'h0000, 4'd12}, // R12
    '{4'b1100, 1'b1, 16'hC3C3, 0,0,0,0,0, 16'hC3C3,16'hC3C3,16'h0077,16'h20FF,16'h0000, 4'd4},  // R4
    '{4'b1000, 1'b0, 16'h1180, 0,0,0,0,0, 16'h0080,16'hC3C3,16'h0077,16'h20FF,16'h0000, 4'd2}   // R2
  };

  task automatic check(input string what, input int req, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_regs(input int req, input logic [15:0] ea, ex, ey, es);
    check("a_q", req, a_q, ea);
    check("x_q", req, x_q, ex);
    check("y_q", req, y_q, ey);
    check("s_q", req, s_q, es);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_regs(1, 16'h0000, 16'h0000, 16'h0000, 16'h0100); // R1 reset state
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {ld_a, ld_x, ld_y, ld_s} = VEC[i].ld;
      ld_wide = VEC[i].wide;
      ld_data = VEC[i].data;
      push = VEC[i].psh;
      pull = VEC[i].pll;
      stk_sel = VEC[i].sel;
      stk_wide = VEC[i].swide;
      #1;
      if (VEC[i].chka) check("stk_addr", int'(VEC[i].req), stk_addr, VEC[i].eaddr);
      @(posedge clk);
      #1;
      {ld_a, ld_x, ld_y, ld_s} = 4'b0000;
      push = 0; pull = 0;
      check_regs(int'(VEC[i].req), VEC[i].ea, VEC[i].ex, VEC[i].ey, VEC[i].es);
    end
    // R1: reset in mid-run restores the defaults
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_regs(1, 16'h0000, 16'h0000, 16'h0000, 16'h0100);
    @(negedge clk);
    rst_n = 1'b1;
    // R7: 8-bit pull from 0x01FF wraps to 0x0100
    ld_s = 1; ld_wide = 0; ld_data = 16'h00FF;
    @(negedge clk);
    ld_s = 0; pull = 1; stk_sel = 0; stk_wide = 0;
    #1;
    check("stk_addr", 7, stk_addr, 16'h0100);
    @(negedge clk);
    pull = 0;
    check("s_q", 7, s_q, 16'h0100);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule